// File: doc/BRIEF.md
# Three-Wire Addressed Control Slave

This block is the peripheral end of a three-wire control bus made of a bus clock, a shared open-drain data line and an identity line. The controller frames every transfer with the identity line. While identity is low it shifts in an address, and while identity is high it shifts in a data byte. A short low pulse on identity then ends the frame. The block answers a block of eight consecutive addresses and keeps one holding register per address. The contents of these registers leave the block as parallel level outputs, so that the surrounding logic can steer its function settings.

The bus clock is normally slower than the system clock. All three bus lines, and also the two status pins, pass through a two-stage synchroniser. Their edges are detected in the system clock domain. The top address of the block is a read command. During its data phase the block answers on the shared line: it pulls the line low, or releases it, to report two status pins that were captured when the address phase ended. The controller sets the pace of the bus, and the block exerts no back-pressure. The register outputs are plain levels with no valid/ready handshake. A new value is present from the cycle in which it is committed until the next commit or reset.

Top module: `tcw_ctrl_slave`

## Requirements
- R1: A synchronous active-high reset clears all eight holding registers to 0x00, clears the latched address, and releases the data line (`bus_data_pull_o` = 0).
- R2: Data is sampled on each rising bus clock, most significant bit first. Only the last 8 bits clocked before identity rises form the address, so any earlier bits are discarded.
- R3: An address from 0x40 to 0x47 is accepted, and its low three bits select holding register 0 to 7. The register for function k appears on `func_o[8k+7:8k]`.
- R4: The last 8 bits clocked while identity is high (first bit = bit 7) become the data byte of the frame.
- R5: A holding register keeps its old value through the data phase. It takes the new byte only when identity falls and then rises again after at least one data bit has been clocked.
- R6: If identity falls during the data phase before any data bit has been clocked, no register is written and address collection restarts.
- R7: An address outside 0x40–0x47 never causes a register write, and the block never pulls the data line for that frame.
- R8: With address 0x47, the block pulls the line low for the first data bit if status pin 0 is low, and for the second data bit if status pin 1 is low. In every other case it releases the line. The pin states are those present when identity rose at the end of the address.
- R9: A frame to the read address 0x47 writes no holding register, and register 7 therefore stays 0x00.
- R10: A change on a bus line reaches the outputs on the third system clock edge after it, because of two synchroniser stages and one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Bus clock, idle high |
| bus_id_i | input | 1 | Identity line, idle high |
| bus_data_i | input | 1 | Resolved level of the shared data line |
| stat_i | input | 2 | Status pins, idle high |
| bus_data_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |
| func_o | output | 64 | Eight holding registers, function k at bits 8k+7:8k |

## Verification
Every register update and every change of the pull output is due on the third system clock edge after the bus line change that causes it. The bench holds each bus level for five system cycles. Its reference model advances at the moment a line is driven, and the model is compared against the outputs on each cycle in which at least three edges have passed since the last drive. One frame end is stepped by hand and checked at the second edge (old value still present) and at the third edge (new value present). This pins the latency down exactly.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_END  = 2'd3
  } phase_t;
endpackage

// File: rtl/tcw_sync.sv
// Multi-stage synchroniser; resets to the bus idle level (all ones).
module tcw_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tcw_frame.sv
// Frame decoder: edge detection, shift register, phase tracking, readback.
module tcw_frame
  import tcw_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          NFUNC     = 8,
  parameter int          NSTAT     = 2,
  parameter int unsigned BASE_ADDR = 'h40,
  parameter int          READ_IDX  = 7,
  localparam int         IDX_W     = $clog2(NFUNC),
  localparam int         CNT_W     = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_clk,
  input  logic             s_id,
  input  logic             s_data,
  input  logic [NSTAT-1:0] s_stat,
  output logic             id_rise,
  output logic             hit,
  output logic [CNT_W-1:0] cnt,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [W-1:0]     wr_data,
  output logic             pull
);
  localparam logic [W-1:0]     BASE_V = W'(BASE_ADDR);
  localparam logic [IDX_W-1:0] RD_SEL = IDX_W'(READ_IDX);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(W);

  phase_t           ph;
  logic             clk_q, id_q;
  logic             clk_rise, id_fall;
  logic [W-1:0]     sh;
  logic [IDX_W-1:0] sel;
  logic [NSTAT-1:0] stat_l;
  logic             addr_match;

  assign clk_rise   = s_clk & ~clk_q;
  assign id_rise    = s_id & ~id_q;
  assign id_fall    = ~s_id & id_q;
  assign addr_match = (sh[W-1:IDX_W] == BASE_V[W-1:IDX_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q  <= 1'b1;
      id_q   <= 1'b1;
      ph     <= PH_IDLE;
      sh     <= '0;
      hit    <= 1'b0;
      sel    <= '0;
      cnt    <= '0;
      stat_l <= '1;
    end else begin
      clk_q <= s_clk;
      id_q  <= s_id;
      if (clk_rise) sh <= {sh[W-2:0], s_data};
      unique case (ph)
        PH_IDLE: if (id_fall) ph <= PH_ADDR;
        PH_ADDR: begin
          if (id_rise) begin
            hit    <= addr_match;
            sel    <= sh[IDX_W-1:0];
            stat_l <= s_stat;
            cnt    <= '0;
            ph     <= PH_DATA;
          end
        end
        PH_DATA: begin
          if (clk_rise && cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (id_fall) ph <= (cnt != '0) ? PH_END : PH_ADDR;
        end
        PH_END: if (id_rise) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign wr_en   = (ph == PH_END) && id_rise && hit && (sel != RD_SEL);
  assign wr_idx  = sel;
  assign wr_data = sh;

  always_comb begin
    pull = 1'b0;
    if (ph == PH_DATA && hit && sel == RD_SEL) begin
      for (int i = 0; i < NSTAT; i++) begin
        if (cnt == CNT_W'(i) && !stat_l[i]) pull = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcw_regbank.sv
// Function holding registers, one per address of the block.
module tcw_regbank #(
  parameter int W     = 8,
  parameter int NFUNC = 8,
  localparam int IDX_W = $clog2(NFUNC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [W-1:0]       wr_data,
  output logic [NFUNC*W-1:0] func_o
);
  for (genvar g = 0; g < NFUNC; g++) begin : g_reg
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) r <= wr_data;
    end
    assign func_o[g*W +: W] = r;
  end
endmodule

// File: rtl/tcw_ctrl_slave.sv
module tcw_ctrl_slave #(
  parameter int          BYTE_W      = 8,
  parameter int          NFUNC       = 8,
  parameter int          NSTAT       = 2,
  parameter int unsigned BASE_ADDR   = 'h40,
  parameter int          READ_IDX    = 7,
  parameter int          SYNC_STAGES = 2,
  localparam int         IDX_W       = $clog2(NFUNC),
  localparam int         CNT_W       = $clog2(BYTE_W + 1),
  localparam int         SYNC_W      = 3 + NSTAT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_clk_i,
  input  logic                    bus_id_i,
  input  logic                    bus_data_i,
  input  logic [NSTAT-1:0]        stat_i,
  output logic                    bus_data_pull_o,
  output logic [NFUNC*BYTE_W-1:0] func_o
);
  logic [SYNC_W-1:0] sync_q;
  logic              id_rise, hit, wr_en;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  tcw_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({stat_i, bus_data_i, bus_id_i, bus_clk_i}),
    .q   (sync_q)
  );

  tcw_frame #(
    .W(BYTE_W), .NFUNC(NFUNC), .NSTAT(NSTAT),
    .BASE_ADDR(BASE_ADDR), .READ_IDX(READ_IDX)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .s_clk   (sync_q[0]),
    .s_id    (sync_q[1]),
    .s_data  (sync_q[2]),
    .s_stat  (sync_q[SYNC_W-1:3]),
    .id_rise (id_rise),
    .hit     (hit),
    .cnt     (cnt),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .pull    (bus_data_pull_o)
  );

  tcw_regbank #(.W(BYTE_W), .NFUNC(NFUNC)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .func_o  (func_o)
  );
endmodule

// File: rtl/tcw_ctrl_slave_chk.sv
module tcw_ctrl_slave_chk #(
  parameter int FW       = 64,
  parameter int CNT_W    = 4,
  parameter int IDX_W    = 3,
  parameter int NSTAT    = 2,
  parameter int READ_IDX = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [FW-1:0]    func_o,
  input logic             pull,
  input logic             id_rise,
  input logic             hit,
  input logic [CNT_W-1:0] cnt,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (func_o == '0 && !pull));

  // R5
  commit_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(func_o)) |-> $past(id_rise));

  // R7
  pull_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pull |-> hit);

  // R8
  pull_window_chk: assert property (@(posedge clk) disable iff (rst)
    pull |-> (cnt < CNT_W'(NSTAT)));

  // R9
  no_read_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx != IDX_W'(READ_IDX)));
endmodule

bind tcw_ctrl_slave tcw_ctrl_slave_chk #(
  .FW(NFUNC*BYTE_W), .CNT_W(CNT_W), .IDX_W(IDX_W),
  .NSTAT(NSTAT), .READ_IDX(READ_IDX)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .func_o  (func_o),
  .pull    (bus_data_pull_o),
  .id_rise (id_rise),
  .hit     (hit),
  .cnt     (cnt),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx)
);

// File: tb/tb_tcw_ctrl_slave.sv
`timescale 1ns/1ps
module tb_tcw_ctrl_slave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_clk = 1'b1;
  logic        bus_id = 1'b1;
  logic        master = 1'b1;
  logic [1:0]  stat = 2'b11;
  logic        pull;
  logic [63:0] func;
  logic        bus_line;

  assign bus_line = master & ~pull;

  tcw_ctrl_slave dut (
    .clk(clk), .rst(rst), .bus_clk_i(bus_clk), .bus_id_i(bus_id),
    .bus_data_i(bus_line), .stat_i(stat),
    .bus_data_pull_o(pull), .func_o(func)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference model
  int         m_ph;    // 0 idle, 1 address, 2 data, 3 end pulse
  bit         q_bits[$];
  logic [7:0] m_regs [8];
  bit         m_hit;
  int         m_sel;
  int         m_cnt;
  logic [1:0] m_stat;
  logic [7:0] cap;
  bit         pull_seen;

  function automatic logic [7:0] last8();
    logic [7:0] v = 8'h00;
    foreach (q_bits[k]) v = {v[6:0], q_bits[k]};
    return v;
  endfunction

  function automatic logic exp_pull();
    if (m_ph == 2 && m_hit && m_sel == 7 && m_cnt < 2) return !m_stat[m_cnt];
    return 1'b0;
  endfunction

  function automatic logic [63:0] exp_func();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = m_regs[k];
    return v;
  endfunction

  task automatic model_reset();
    m_ph = 0; q_bits.delete(); m_hit = 0; m_sel = 0; m_cnt = 0; m_stat = 2'b11;
    for (int k = 0; k < 8; k++) m_regs[k] = 8'h00;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic i, logic d);
    master = d;
    if (c && !bus_clk) begin
      q_bits.push_back(d & ~exp_pull());
      if (q_bits.size() > 8) void'(q_bits.pop_front());
      if (m_ph == 2 && m_cnt < 8) m_cnt++;
    end
    if (!i && bus_id) begin
      if (m_ph == 0) m_ph = 1;
      else if (m_ph == 2) m_ph = (m_cnt != 0) ? 3 : 1;
    end
    if (i && !bus_id) begin
      if (m_ph == 1) begin
        logic [7:0] a = last8();
        m_hit = (a[7:3] == 5'b01000); m_sel = int'(a[2:0]);
        m_stat = stat; m_cnt = 0; m_ph = 2;
      end else if (m_ph == 3) begin
        if (m_hit && m_sel != 7) m_regs[m_sel] = last8();
        m_ph = 0;
      end
    end
    bus_clk = c; bus_id = i;
    for (int age = 1; age <= 5; age++) begin
      @(posedge clk); @(negedge clk);
      if (pull) pull_seen = 1;
      if (age >= 3) begin
        chk("R4 registers vs model", func, exp_func());
        chk("R8 pull vs model", {63'd0, pull}, {63'd0, exp_pull()});
      end
    end
  endtask

  task automatic send_bits(logic [15:0] v, int n, logic i);
    for (int k = n - 1; k >= 0; k--) begin
      step(1'b0, i, v[k]);
      cap = {cap[6:0], bus_line};
      step(1'b1, i, v[k]);
      step(1'b0, i, v[k]);
    end
  endtask

  task automatic frame(logic [15:0] a, int n, logic [7:0] d, bit fin);
    step(1'b0, 1'b0, 1'b1);
    send_bits(a, n, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    cap = 8'h00;
    send_bits({8'h00, d}, 8, 1'b1);
    if (fin) begin
      step(1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'b1);
      step(1'b1, 1'b1, 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 regs after reset", func, 64'd0);
    chk("R1 line released", {63'd0, pull}, 64'd0);

    frame(16'h40, 8, 8'hA5, 1);
    chk("R3 reg0 written", {56'd0, func[7:0]}, 64'hA5);
    frame(16'h46, 8, 8'h3C, 1);
    chk("R3 reg6 written", {56'd0, func[55:48]}, 64'h3C);
    // R2 leading junk bits dropped
    frame(16'hF42, 12, 8'h5A, 1);
    chk("R2 last 8 address bits", {56'd0, func[23:16]}, 64'h5A);

    // R5 held until end pulse, R10 latency
    frame(16'h42, 8, 8'h11, 0);
    chk("R5 held before pulse", {56'd0, func[23:16]}, 64'h5A);
    step(1'b0, 1'b0, 1'b1);
    bus_id = 1'b1;
    m_regs[2] = 8'h11; m_ph = 0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R10 old value at edge 2", {56'd0, func[23:16]}, 64'h5A);
    @(posedge clk); @(negedge clk);
    chk("R10 new value at edge 3", {56'd0, func[23:16]}, 64'h11);
    step(1'b1, 1'b1, 1'b1);

    // R7 out-of-range addresses
    pull_seen = 0;
    stat = 2'b00;
    frame(16'h48, 8, 8'hFF, 1);
    frame(16'h3F, 8, 8'h77, 1);
    stat = 2'b11;
    chk("R7 no write", func, {8'h00, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h11, 8'h00, 8'hA5});
    chk("R7 line never pulled", {63'd0, pull_seen}, 64'd0);

    // R6 identity drop with no data bit restarts addressing
    step(1'b0, 1'b0, 1'b1);
    send_bits(16'h43, 8, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    send_bits(16'h45, 8, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    send_bits(16'h99, 8, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk("R6 second address used", {56'd0, func[47:40]}, 64'h99);
    chk("R6 first address unwritten", {56'd0, func[31:24]}, 64'h00);

    // R8 readback, R9 no write on read
    stat = 2'b10;
    frame(16'h47, 8, 8'hFF, 1);
    chk("R8 readback pin0 low", {56'd0, cap}, 64'h7F);
    stat = 2'b01;
    frame(16'h47, 8, 8'hFF, 1);
    chk("R8 readback pin1 low", {56'd0, cap}, 64'hBF);
    stat = 2'b00;
    frame(16'h47, 8, 8'hFF, 1);
    chk("R8 readback both low", {56'd0, cap}, 64'h3F);
    stat = 2'b11;
    chk("R9 reg7 stays zero", {56'd0, func[63:56]}, 64'h00);
    chk("R9 other regs kept", func, {8'h00, 8'h3C, 8'h99, 8'h00, 8'h00, 8'h11, 8'h00, 8'hA5});

    // R1 mid-run reset
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 regs after late reset", func, 64'd0);
    frame(16'h41, 8, 8'hC3, 1);
    chk("R4 write after reset", {56'd0, func[15:8]}, 64'hC3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule